// File: doc/BRIEF.md
# Runtime Vertical-Link Lane Repair Unit

This unit sits between a logic die and a stacked DRAM die and drives the parallel bundle of through-silicon lanes that carries each transfer's address and data. It sends every transfer out on the physical lanes, rebuilds the logical address and data from the lanes that come back, and compares a CRC-32 of both. A mismatch is flagged to the system. The system can then start a built-in self test. The test walks a single one and then a single zero across every lane in loopback and records each lane whose returned value is wrong.

The unit has no spare lanes of its own. The top few ordinary data lanes are the standby pool. The bits they normally carry are also held in ECC space, so the ECC copy arrives on a side input. After the test, each newly failed lane is steered onto a free standby lane. The same remap is applied on the outgoing and the incoming path, and the logical bit that the standby lane used to carry is taken from the ECC copy. Address lanes are repaired first, because one broken address lane cuts off half the memory, while a broken data lane only spoils a few columns. When a fault cannot be repaired, a sticky uncorrectable status is raised and no further remapping takes place.

Top module: `tsv_lane_swap`

## Requirements
- R1: After reset, bist_busy, bist_done, crc_err and uncorrectable are 0, standby_free equals STBY_LANES, and lane mapping is the identity.
- R2: Outside the self test, with no repairs, physical lane i carries tx_addr[i] for i < ADDR_LANES and tx_data[i-ADDR_LANES] above that; rd_addr and rd_data are rebuilt from lane_rx with the same mapping.
- R3: One cycle after a transfer accepted with tx_valid=1 and bist_busy=0, crc_err is 1 exactly when the CRC-32 (polynomial 0x04C11DB7, initial value all ones, MSB first over {data,addr}) of the rebuilt word differs from that of the sent word; otherwise it is 0.
- R4: A bist_start pulse while idle and not uncorrectable makes bist_busy 1 from the next cycle; transfers offered while bist_busy is 1 are ignored and raise no crc_err.
- R5: The self test drives a walking one and then a walking zero over all lanes, and marks every lane whose returned value differs, whether it is stuck at 0 or stuck at 1.
- R6: Standby entry k owns physical lane ADDR_LANES+DATA_LANES-STBY_LANES+k, which normally carries data bit DATA_LANES-STBY_LANES+k. A repaired lane's bit is sent on its standby lane and read back from it, and standby_free drops by one per repair.
- R7: While standby entry k is in use, rd_data bit DATA_LANES-STBY_LANES+k is taken from ecc_copy[k].
- R8: A failed standby lane whose own entry is free is retired onto its own entry; its bit then comes from the ECC copy.
- R9: Failed lanes are repaired lowest physical index first, so address lanes are served before data lanes, and each takes the lowest free entry whose lane is healthy.
- R10: If a failed lane finds no usable entry, or a standby lane in service fails, uncorrectable is set and stays set, the remap table no longer changes, and bist_start is ignored.
- R11: bist_done is a one-cycle pulse in the first cycle that bist_busy is 0 after a test, and bist_busy falls only together with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_valid | input | 1 | A transfer is offered this cycle |
| tx_addr | input | ADDR_LANES | Logical address to send |
| tx_data | input | DATA_LANES | Logical data to send |
| ecc_copy | input | STBY_LANES | ECC-held copy of the standby lanes' data bits |
| lane_tx | output | ADDR_LANES+DATA_LANES | Physical lanes driven toward the stacked die |
| lane_rx | input | ADDR_LANES+DATA_LANES | Physical lanes returned from the stacked die |
| rd_addr | output | ADDR_LANES | Rebuilt logical address |
| rd_data | output | DATA_LANES | Rebuilt logical data |
| crc_err | output | 1 | CRC mismatch on the previous accepted transfer |
| bist_start | input | 1 | Request a self test and repair pass |
| bist_busy | output | 1 | Self test or repair in progress; traffic held off |
| bist_done | output | 1 | One-cycle pulse when a pass ends |
| uncorrectable | output | 1 | Sticky: a fault could not be repaired |
| standby_free | output | $clog2(STBY_LANES+1) | Number of unused standby entries |

## Verification
On every cycle, the assertions check the following. The remap table only grows and is frozen once the block is uncorrectable. The uncorrectable flag never clears. The test patterns hold exactly one active or one inactive lane. No CRC error appears while the lanes are held for testing. The end-of-test pulse coincides with the fall of the busy signal. Only the bench scenarios can show the rest: which lane a given stuck fault is steered to, address-before-data ordering under a shortage, a standby lane retiring onto its own entry, and the ECC copy reappearing on the logical data port.

// File: rtl/tsv_swap_pkg.sv
package tsv_swap_pkg;
   localparam logic [31:0] CRC32_POLY = 32'h04C1_1DB7;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_WALK1 = 2'd1,
      ST_WALK0 = 2'd2,
      ST_FIX   = 2'd3
   } bist_st_e;
endpackage

// File: rtl/lane_crc_chk.sv
module lane_crc_chk #(
   parameter int W = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         chk_en,
   input  logic [W-1:0] sent,
   input  logic [W-1:0] got,
   output logic         crc_err
);
   import tsv_swap_pkg::*;

   function automatic logic [31:0] crc_of(input logic [W-1:0] d);
      logic [31:0] c;
      c = '1;
      for (int i = W - 1; i >= 0; i--) begin
         if (c[31] ^ d[i]) c = {c[30:0], 1'b0} ^ CRC32_POLY;
         else              c = {c[30:0], 1'b0};
      end
      return c;
   endfunction

   logic [31:0] crc_sent, crc_got;
   assign crc_sent = crc_of(sent);
   assign crc_got  = crc_of(got);

   always_ff @(posedge clk) begin
      if (!rst_n) crc_err <= 1'b0;
      else        crc_err <= chk_en && (crc_sent != crc_got);
   end
endmodule

// File: rtl/lane_xbar.sv
module lane_xbar #(
   parameter int A  = 8,
   parameter int D  = 16,
   parameter int S  = 2,
   parameter int N  = A + D,
   parameter int IW = $clog2(N)
) (
   input  logic [S-1:0]         entry_vld,
   input  logic [S-1:0][IW-1:0] entry_src,
   input  logic                 bist_act,
   input  logic [N-1:0]         bist_pat,
   input  logic [A-1:0]         tx_addr,
   input  logic [D-1:0]         tx_data,
   input  logic [S-1:0]         ecc_copy,
   output logic [N-1:0]         lane_tx,
   input  logic [N-1:0]         lane_rx,
   output logic [A-1:0]         rd_addr,
   output logic [D-1:0]         rd_data
);
   localparam int SB0 = N - S;

   logic [N-1:0] base, mapped, logical;

   always_comb begin
      base   = {tx_data, tx_addr};
      mapped = base;
      for (int k = 0; k < S; k++)
         if (entry_vld[k]) mapped[SB0+k] = base[entry_src[k]];
      lane_tx = bist_act ? bist_pat : mapped;
   end

   always_comb begin
      logical = lane_rx;
      for (int k = 0; k < S; k++)
         if (entry_vld[k]) logical[entry_src[k]] = lane_rx[SB0+k];
      // ECC copy wins last, which also covers a standby retired onto itself
      for (int k = 0; k < S; k++)
         if (entry_vld[k]) logical[SB0+k] = ecc_copy[k];
   end

   assign rd_addr = logical[A-1:0];
   assign rd_data = logical[N-1:A];
endmodule

// File: rtl/lane_bist.sv
module lane_bist #(
   parameter int N  = 24,
   parameter int IW = $clog2(N)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         unc,
   input  logic         fix_done,
   input  logic [N-1:0] lane_rx,
   output logic         act,
   output logic [N-1:0] pat,
   output logic [N-1:0] bad,
   output logic         in_fix,
   output logic         busy,
   output logic         done
);
   import tsv_swap_pkg::*;

   bist_st_e      st;
   logic [IW-1:0] cnt;
   logic [N-1:0]  one_hot;
   logic          last;

   assign one_hot = N'(1) << cnt;
   assign pat     = (st == ST_WALK0) ? ~one_hot : one_hot;
   assign act     = (st == ST_WALK1) || (st == ST_WALK0);
   assign in_fix  = (st == ST_FIX);
   assign busy    = (st != ST_IDLE);
   assign last    = (cnt == IW'(N - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st   <= ST_IDLE;
         cnt  <= '0;
         bad  <= '0;
         done <= 1'b0;
      end else begin
         done <= (st == ST_FIX) && fix_done;
         case (st)
            ST_IDLE: if (start && !unc) begin
               st  <= ST_WALK1;
               cnt <= '0;
               bad <= '0;
            end
            ST_WALK1, ST_WALK0: begin
               bad <= bad | (lane_rx ^ pat);
               cnt <= last ? '0 : cnt + 1'b1;
               if (last) st <= (st == ST_WALK1) ? ST_WALK0 : ST_FIX;
            end
            default: if (fix_done) st <= ST_IDLE;
         endcase
      end
   end

   p_walk1_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WALK1) |-> ($countones(lane_rx ^ lane_rx) == 0 && $countones(pat) == 1));
   p_walk0_onezero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_WALK0) |-> ($countones(~pat) == 1));
   p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   p_busy_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);
endmodule

// File: rtl/lane_remap_table.sv
module lane_remap_table #(
   parameter int A  = 8,
   parameter int D  = 16,
   parameter int S  = 2,
   parameter int N  = A + D,
   parameter int IW = $clog2(N),
   parameter int FW = $clog2(S + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 fix,
   input  logic [N-1:0]         bad,
   output logic [S-1:0]         entry_vld,
   output logic [S-1:0][IW-1:0] entry_src,
   output logic                 fix_done,
   output logic                 unc,
   output logic [FW-1:0]        free_cnt
);
   localparam int SB0 = N - S;
   localparam int KW  = (S > 1) ? $clog2(S) : 1;

   logic [N-1:0]  repaired, cand;
   logic          has_c, has_f, is_sb, do_assign, do_unc;
   logic [IW-1:0] c_idx;
   logic [KW-1:0] kf, ks, tgt;

   always_comb begin
      repaired = '0;
      for (int k = 0; k < S; k++)
         if (entry_vld[k]) repaired[entry_src[k]] = 1'b1;
      cand  = bad & ~repaired;
      has_c = 1'b0;
      c_idx = '0;
      for (int i = N - 1; i >= 0; i--)
         if (cand[i]) begin has_c = 1'b1; c_idx = IW'(i); end
      has_f = 1'b0;
      kf    = '0;
      for (int k = S - 1; k >= 0; k--)
         if (!entry_vld[k] && !bad[SB0+k]) begin has_f = 1'b1; kf = KW'(k); end
      is_sb     = has_c && (int'(c_idx) >= SB0);
      ks        = is_sb ? KW'(int'(c_idx) - SB0) : '0;
      do_assign = 1'b0;
      do_unc    = 1'b0;
      fix_done  = 1'b0;
      tgt       = '0;
      if (fix) begin
         if (!has_c)                      fix_done = 1'b1;
         else if (is_sb && entry_vld[ks]) begin do_unc = 1'b1; fix_done = 1'b1; end
         else if (is_sb)                  begin do_assign = 1'b1; tgt = ks; end
         else if (has_f)                  begin do_assign = 1'b1; tgt = kf; end
         else                             begin do_unc = 1'b1; fix_done = 1'b1; end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         entry_vld <= '0;
         entry_src <= '0;
         unc       <= 1'b0;
      end else begin
         if (do_assign) begin
            entry_vld[tgt] <= 1'b1;
            entry_src[tgt] <= c_idx;
         end
         if (do_unc) unc <= 1'b1;
      end
   end

   assign free_cnt = FW'(S - $countones(entry_vld));

   p_table_grows_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(entry_vld) >= $past($countones(entry_vld)));
   p_unc_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      unc |=> unc);
   p_frozen_after_unc_r10: assert property (@(posedge clk) disable iff (!rst_n)
      unc |=> $stable(entry_vld) && $stable(entry_src));
endmodule

// File: rtl/tsv_lane_swap.sv
module tsv_lane_swap #(
   parameter int ADDR_LANES = 8,
   parameter int DATA_LANES = 16,
   parameter int STBY_LANES = 2,
   localparam int N  = ADDR_LANES + DATA_LANES,
   localparam int IW = $clog2(N),
   localparam int FW = $clog2(STBY_LANES + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  tx_valid,
   input  logic [ADDR_LANES-1:0] tx_addr,
   input  logic [DATA_LANES-1:0] tx_data,
   input  logic [STBY_LANES-1:0] ecc_copy,
   output logic [N-1:0]          lane_tx,
   input  logic [N-1:0]          lane_rx,
   output logic [ADDR_LANES-1:0] rd_addr,
   output logic [DATA_LANES-1:0] rd_data,
   output logic                  crc_err,
   input  logic                  bist_start,
   output logic                  bist_busy,
   output logic                  bist_done,
   output logic                  uncorrectable,
   output logic [FW-1:0]         standby_free
);
   generate
      if (STBY_LANES < 1 || STBY_LANES > DATA_LANES)
         $error("STBY_LANES must lie in 1..DATA_LANES");
      if (ADDR_LANES < 1)
         $error("ADDR_LANES must be at least 1");
   endgenerate

   logic [STBY_LANES-1:0]         entry_vld;
   logic [STBY_LANES-1:0][IW-1:0] entry_src;
   logic                          act, in_fix, fix_done;
   logic [N-1:0]                  pat, bad;

   lane_bist #(.N(N), .IW(IW)) u_bist (
      .clk(clk), .rst_n(rst_n), .start(bist_start), .unc(uncorrectable),
      .fix_done(fix_done), .lane_rx(lane_rx), .act(act), .pat(pat),
      .bad(bad), .in_fix(in_fix), .busy(bist_busy), .done(bist_done)
   );

   lane_remap_table #(.A(ADDR_LANES), .D(DATA_LANES), .S(STBY_LANES), .N(N), .IW(IW), .FW(FW)) u_table (
      .clk(clk), .rst_n(rst_n), .fix(in_fix), .bad(bad), .entry_vld(entry_vld),
      .entry_src(entry_src), .fix_done(fix_done), .unc(uncorrectable),
      .free_cnt(standby_free)
   );

   lane_xbar #(.A(ADDR_LANES), .D(DATA_LANES), .S(STBY_LANES), .N(N), .IW(IW)) u_xbar (
      .entry_vld(entry_vld), .entry_src(entry_src), .bist_act(act), .bist_pat(pat),
      .tx_addr(tx_addr), .tx_data(tx_data), .ecc_copy(ecc_copy), .lane_tx(lane_tx),
      .lane_rx(lane_rx), .rd_addr(rd_addr), .rd_data(rd_data)
   );

   lane_crc_chk #(.W(N)) u_crc (
      .clk(clk), .rst_n(rst_n), .chk_en(tx_valid && !bist_busy),
      .sent({tx_data, tx_addr}), .got({rd_data, rd_addr}), .crc_err(crc_err)
   );

   p_quiet_while_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bist_busy && $past(bist_busy)) |-> !crc_err);
   p_start_takes_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bist_start && !bist_busy && !uncorrectable) |=> bist_busy);
endmodule

// File: tb/tsv_lane_swap_tb.sv
module tsv_lane_swap_tb;
   localparam int CLK_P = 10;
   localparam int A = 8, D = 16, S = 2, N = A + D;

   logic clk = 1'b0, rst_n = 1'b0;
   logic tx_valid = 1'b0, bist_start = 1'b0;
   logic [A-1:0] tx_addr = '0;
   logic [D-1:0] tx_data = '0;
   logic [S-1:0] ecc_copy = '0;
   logic [N-1:0] lane_tx, lane_rx, stuck_m = '0, stuck_v = '0;
   logic [A-1:0] rd_addr;
   logic [D-1:0] rd_data;
   logic crc_err, bist_busy, bist_done, uncorrectable;
   logic [1:0] standby_free;
   int n_chk = 0, n_bad = 0;

   always #(CLK_P/2) clk = ~clk;
   assign lane_rx = (lane_tx & ~stuck_m) | (stuck_v & stuck_m);

   tsv_lane_swap #(.ADDR_LANES(A), .DATA_LANES(D), .STBY_LANES(S)) u_dut (
      .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_addr(tx_addr), .tx_data(tx_data),
      .ecc_copy(ecc_copy), .lane_tx(lane_tx), .lane_rx(lane_rx), .rd_addr(rd_addr),
      .rd_data(rd_data), .crc_err(crc_err), .bist_start(bist_start), .bist_busy(bist_busy),
      .bist_done(bist_done), .uncorrectable(uncorrectable), .standby_free(standby_free)
   );

   task automatic chk(input bit ok, input string req, input string what);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: %s", req, what);
      end
   endtask

   task automatic do_reset();
      stuck_m = '0; stuck_v = '0; tx_valid = 0; bist_start = 0;
      @(negedge clk); rst_n = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
   endtask

   task automatic stick(input int lane, input bit v);
      stuck_m[lane] = 1'b1; stuck_v[lane] = v;
   endtask

   // drive one transfer; returns crc_err seen one cycle later
   task automatic xfer(input logic [A-1:0] a, input logic [D-1:0] d, output logic err);
      @(negedge clk);
      tx_valid = 1; tx_addr = a; tx_data = d; ecc_copy = d[D-1:D-S];
      @(negedge clk);
      tx_valid = 0;
      err = crc_err;
   endtask

   task automatic run_bist(input string req);
      int waited = 0;
      @(negedge clk);
      bist_start = 1;
      @(negedge clk);
      bist_start = 0;
      chk(bist_busy === 1'b1, "R4", $sformatf("busy=%0b exp=1 after start (%s)", bist_busy, req));
      tx_valid = 1; tx_addr = 8'hFF; tx_data = 16'hFFFF;
      while (!bist_done && waited < 200) begin
         @(negedge clk);
         waited++;
         if (bist_busy) chk(crc_err === 1'b0, "R4", $sformatf("crc_err=%0b exp=0 while busy", crc_err));
      end
      tx_valid = 0;
      chk(bist_done === 1'b1 && bist_busy === 1'b0, "R11",
          $sformatf("done=%0b busy=%0b exp 1/0", bist_done, bist_busy));
      @(negedge clk);
      chk(bist_done === 1'b0, "R11", $sformatf("done=%0b exp=0 second cycle", bist_done));
   endtask

   task automatic t_reset();
      do_reset();
      #1;
      chk({bist_busy, bist_done, crc_err, uncorrectable} === 4'b0, "R1",
          $sformatf("flags=%b exp=0000", {bist_busy, bist_done, crc_err, uncorrectable}));
      chk(standby_free === 2'd2, "R1", $sformatf("free=%0d exp=2", standby_free));
   endtask

   task automatic t_clean();
      logic e;
      logic [A-1:0] av [3] = '{8'hA5, 8'h3C, 8'h00};
      logic [D-1:0] dv [3] = '{16'hC3F0, 16'h0FFF, 16'hFFFF};
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         tx_valid = 1; tx_addr = av[i]; tx_data = dv[i]; ecc_copy = dv[i][D-1:D-S];
         #1;
         chk(lane_tx === {dv[i], av[i]}, "R2", $sformatf("lane_tx=%h exp=%h", lane_tx, {dv[i], av[i]}));
         chk(rd_addr === av[i] && rd_data === dv[i], "R2",
             $sformatf("rd=%h/%h exp=%h/%h", rd_addr, rd_data, av[i], dv[i]));
         @(negedge clk);
         tx_valid = 0;
         chk(crc_err === 1'b0, "R3", $sformatf("crc_err=%0b exp=0 clean", crc_err));
      end
      xfer(8'h01, 16'h0001, e);
      chk(e === 1'b0, "R3", $sformatf("crc_err=%0b exp=0", e));
   endtask

   task automatic t_data_fault();
      logic e;
      t_reset();
      stick(A + 2, 1'b0);                         // data bit 2 stuck at 0
      xfer(8'h00, 16'h0004, e);
      chk(e === 1'b1, "R3", $sformatf("crc_err=%0b exp=1 on stuck lane", e));
      run_bist("R5");
      chk(standby_free === 2'd1, "R6", $sformatf("free=%0d exp=1", standby_free));
      @(negedge clk);
      tx_valid = 1; tx_addr = 8'h11; tx_data = 16'h0004; ecc_copy = 2'b00;
      #1;
      chk(lane_tx[22] === 1'b1, "R6", $sformatf("lane22=%0b exp=1", lane_tx[22]));
      chk(rd_data === 16'h0004 && rd_addr === 8'h11, "R6",
          $sformatf("rd=%h/%h exp=11/0004", rd_addr, rd_data));
      @(negedge clk);
      tx_valid = 0;
      chk(crc_err === 1'b0, "R6", $sformatf("crc_err=%0b exp=0 after repair", crc_err));
      tx_data = 16'h0000; ecc_copy = 2'b01;        // ECC says bit 14 is 1
      #1;
      chk(rd_data === 16'h4000, "R7", $sformatf("rd_data=%h exp=4000", rd_data));
   endtask

   task automatic t_priority();
      t_reset();
      stick(A + 12, 1'b1);                        // data lane phys 20
      run_bist("R6");
      chk(standby_free === 2'd1, "R6", $sformatf("free=%0d exp=1", standby_free));
      stick(6, 1'b0);                             // address lane 6
      stick(A + 1, 1'b1);                         // data lane phys 9
      run_bist("R9");
      chk(uncorrectable === 1'b1, "R10", $sformatf("unc=%0b exp=1", uncorrectable));
      chk(standby_free === 2'd0, "R9", $sformatf("free=%0d exp=0", standby_free));
      @(negedge clk);
      tx_addr = 8'h40; tx_data = 16'h0000;
      #1;
      chk(lane_tx[23] === 1'b1, "R9", $sformatf("lane23=%0b exp=1 (addr bit 6)", lane_tx[23]));
      chk(rd_addr === 8'h40, "R9", $sformatf("rd_addr=%h exp=40", rd_addr));
      @(negedge clk);
      bist_start = 1;
      @(negedge clk);
      bist_start = 0;
      chk(bist_busy === 1'b0, "R10", $sformatf("busy=%0b exp=0 once uncorrectable", bist_busy));
      chk(uncorrectable === 1'b1 && standby_free === 2'd0, "R10",
          $sformatf("unc=%0b free=%0d exp 1/0", uncorrectable, standby_free));
   endtask

   task automatic t_standby_self();
      logic e;
      t_reset();
      stick(23, 1'b0);                            // free standby lane 1 fails
      run_bist("R8");
      chk(standby_free === 2'd1, "R8", $sformatf("free=%0d exp=1", standby_free));
      xfer(8'h5A, 16'hFFFF, e);
      chk(e === 1'b0, "R8", $sformatf("crc_err=%0b exp=0", e));
      tx_data = 16'hFFFF; ecc_copy = 2'b01;      // ECC copy says bit 15 is 0
      #1;
      chk(rd_data === 16'h7FFF, "R7", $sformatf("rd_data=%h exp=7FFF", rd_data));
      stick(A + 4, 1'b1);                         // data bit 4 stuck at 1
      run_bist("R6");
      tx_data = 16'h0000;
      #1;
      chk(lane_tx[22] === 1'b0 && standby_free === 2'd0, "R6",
          $sformatf("lane22=%0b free=%0d exp 0/0", lane_tx[22], standby_free));
      chk(uncorrectable === 1'b0, "R8", $sformatf("unc=%0b exp=0", uncorrectable));
   endtask

   task automatic t_stuck_high_addr();
      t_reset();
      stick(2, 1'b1);                             // address lane 2 stuck at 1
      run_bist("R5");
      @(negedge clk);
      tx_addr = 8'h00; tx_data = 16'h1234;
      #1;
      chk(lane_tx[22] === 1'b0 && rd_addr === 8'h00, "R5",
          $sformatf("lane22=%0b rd_addr=%h exp 0/00", lane_tx[22], rd_addr));
   endtask

   initial begin
      #(CLK_P * 100000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not end, actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      t_reset();
      t_clean();
      t_data_fault();
      t_priority();
      t_standby_self();
      t_stuck_high_addr();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule